// File: doc/BRIEF.md
# Shared Submission Work Queue

This block is one hardware work queue reached through a single submit address that any number of submitters share. A submission is one atomic descriptor write that always gets a reply. The descriptor holds an operation code, source and destination addresses, a completion-record address and a 20-bit address-space ID that names the submitting process. The queue itself tracks how full it is. When a slot is free and the ID is valid, it stores the whole descriptor and answers with an accept. When it is full, it drops the descriptor and answers with a retry, so the submitter decides whether to try again. A descriptor carrying ID zero gets an error answer.

The submit side is never back-pressured: every strobe gets a reply code one cycle later. Stored descriptors leave in arrival order on a valid/ready stream, together with their ID, to a downstream engine. The stream follows the usual rules. `deq_valid` is high whenever the queue holds an entry. While `deq_valid` is high and `deq_ready` is low, the presented descriptor stays unchanged. A transfer happens on a clock edge where both are high. The downstream side may hold `deq_ready` low for as long as it likes. Back-pressure on the stream never stalls a submitter; it only makes further submissions come back with retry once the queue fills.

Top module: `swq_top`

## Requirements
- R1: A submission is a one-cycle strobe `sub_valid` carrying an 8-bit opcode, three 64-bit addresses and a 20-bit ID. All fields are captured together on that edge, and no partial descriptor ever appears downstream.
- R2: In the cycle after every strobe, `rsp_valid` is high and `rsp_code` holds the result: 2'b00 accept, 2'b01 retry, 2'b10 error. Without a strobe, `rsp_valid` stays low.
- R3: A submission with a nonzero ID is accepted and stored when fewer than 16 entries are held.
- R4: A submission with a nonzero ID that arrives while 16 entries are held is answered with retry and stored nowhere. This holds even if an entry is dequeued on the same edge.
- R5: A submission with ID zero is answered with error and not stored. Error takes precedence over retry.
- R6: Entries leave in first-in first-out order, and each one keeps its opcode, addresses and ID unchanged.
- R7: `deq_valid` is high exactly while the queue is non-empty. While `deq_valid` is high and `deq_ready` is low, the `deq_*` data stays stable.
- R8: After reset the queue is empty, `deq_valid` is low and `rsp_valid` is low.
- R9: A descriptor accepted into an empty queue is presented on `deq_*` in the cycle right after its strobe.
- R10: An accept and a dequeue on the same edge leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | Submission strobe |
| sub_opcode | input | 8 | Operation code |
| sub_src | input | 64 | Source parameter address |
| sub_dst | input | 64 | Destination parameter address |
| sub_cmpl | input | 64 | Completion-record address |
| sub_pasid | input | 20 | Submitter address-space ID |
| rsp_valid | output | 1 | Reply present (one cycle after the strobe) |
| rsp_code | output | 2 | 00 accept, 01 retry, 10 error |
| deq_valid | output | 1 | Stream data present |
| deq_ready | input | 1 | Downstream can take the entry |
| deq_opcode | output | 8 | Head opcode |
| deq_src | output | 64 | Head source address |
| deq_dst | output | 64 | Head destination address |
| deq_cmpl | output | 64 | Head completion address |
| deq_pasid | output | 20 | Head address-space ID |

## Verification
The reply code is registered, so it is due one edge after the strobe. The bench drives every strobe at a falling edge and reads the reply at the next falling edge, after exactly one rising edge. The head of the stream is driven combinationally from storage: a descriptor accepted into an empty queue is checked at the falling edge that follows its write edge, and each pop is checked at the falling edge before the edge that removes it. The case of a full queue and a same-edge dequeue is driven on a single edge, and the result is read both from the reply and from the entries that drain afterwards.

// File: rtl/swq_pkg.sv
package swq_pkg;
  parameter int OPC_W  = 8;
  parameter int ADDR_W = 64;
  parameter int ID_W   = 20;

  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] cmpl;
    logic [ID_W-1:0]   pasid;
  } desc_t;

  typedef enum logic [1:0] {
    RSP_ACCEPT = 2'b00,
    RSP_RETRY  = 2'b01,
    RSP_ERROR  = 2'b10
  } rsp_e;
endpackage

// File: rtl/swq_admit.sv
module swq_admit
  import swq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sub_valid,
  input  logic [ID_W-1:0] sub_pasid,
  input  logic            full,
  output logic            wr_en,
  output logic            rsp_valid,
  output logic [1:0]      rsp_code
);
  logic id_ok;
  rsp_e verdict;

  always_comb begin
    id_ok = (sub_pasid != '0);
    wr_en = sub_valid && id_ok && !full;
    if (!id_ok)     verdict = RSP_ERROR;
    else if (full)  verdict = RSP_RETRY;
    else            verdict = RSP_ACCEPT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_ACCEPT;
    end else begin
      rsp_valid <= sub_valid;
      if (sub_valid) rsp_code <= verdict;
    end
  end

  // R2: reply one cycle after every strobe, none otherwise
  a_r2_reply_due: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_valid |=> !rsp_valid);
  // R5: zero ID gives error
  a_r5_zero_id_error: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_pasid == '0) |=> rsp_code == RSP_ERROR);
  // R4: full queue gives retry
  a_r4_full_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && full && sub_pasid != '0) |=> rsp_code == RSP_RETRY);
endmodule

// File: rtl/swq_store.sv
module swq_store
  import swq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  desc_t wr_data,
  output logic  rd_valid,
  input  logic  rd_ready,
  output desc_t rd_data,
  output logic  full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  desc_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          pop;

  always_comb begin
    full     = (cnt == FULL_CNT);
    rd_valid = (cnt != '0);
    rd_data  = mem[rd_ptr];
    pop      = rd_valid && rd_ready;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && wr_ptr == AW'(i)) mem[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)   rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R4: the admit logic never writes into a full queue
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cnt < FULL_CNT);
  // R3: occupancy never exceeds the depth
  a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
  // R7: a stalled head holds still
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R10: an accept and a pop on one edge keep the occupancy
  a_r10_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pop) |=> cnt == $past(cnt));
endmodule

// File: rtl/swq_top.sv
module swq_top
  import swq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_valid,
  input  logic [OPC_W-1:0]  sub_opcode,
  input  logic [ADDR_W-1:0] sub_src,
  input  logic [ADDR_W-1:0] sub_dst,
  input  logic [ADDR_W-1:0] sub_cmpl,
  input  logic [ID_W-1:0]   sub_pasid,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic              deq_valid,
  input  logic              deq_ready,
  output logic [OPC_W-1:0]  deq_opcode,
  output logic [ADDR_W-1:0] deq_src,
  output logic [ADDR_W-1:0] deq_dst,
  output logic [ADDR_W-1:0] deq_cmpl,
  output logic [ID_W-1:0]   deq_pasid
);
  desc_t in_desc, head;
  logic  wr_en, full;

  assign in_desc = '{opcode: sub_opcode, src: sub_src, dst: sub_dst,
                     cmpl: sub_cmpl, pasid: sub_pasid};

  swq_admit u_admit (
    .clk       (clk),
    .rst_n     (rst_n),
    .sub_valid (sub_valid),
    .sub_pasid (sub_pasid),
    .full      (full),
    .wr_en     (wr_en),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code)
  );

  swq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (in_desc),
    .rd_valid (deq_valid),
    .rd_ready (deq_ready),
    .rd_data  (head),
    .full     (full)
  );

  assign deq_opcode = head.opcode;
  assign deq_src    = head.src;
  assign deq_dst    = head.dst;
  assign deq_cmpl   = head.cmpl;
  assign deq_pasid  = head.pasid;
endmodule

// File: tb/swq_top_test.sv
module swq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  // table entries: {expected reply code, ID}; submitted with deq_ready low from empty
  localparam logic [21:0] VEC [NVEC] = '{
    {2'b00, 20'h00011}, {2'b00, 20'h00022}, {2'b00, 20'hFFFFF}, {2'b10, 20'h00000},
    {2'b00, 20'h00A05}, {2'b00, 20'h12345}, {2'b00, 20'h00001}, {2'b00, 20'h80000},
    {2'b00, 20'h0BEEF}, {2'b00, 20'h00300}, {2'b00, 20'h4C4C4}, {2'b00, 20'h00077},
    {2'b00, 20'h7FFFF}, {2'b00, 20'h01010}, {2'b00, 20'h00999}, {2'b00, 20'h3A3A3},
    {2'b00, 20'h00042}, {2'b01, 20'h00555}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sub_valid = 1'b0, deq_ready = 1'b0;
  logic [7:0] sub_opcode = '0;
  logic [63:0] sub_src = '0, sub_dst = '0, sub_cmpl = '0;
  logic [19:0] sub_pasid = '0;
  logic rsp_valid, deq_valid;
  logic [1:0] rsp_code;
  logic [7:0] deq_opcode;
  logic [63:0] deq_src, deq_dst, deq_cmpl;
  logic [19:0] deq_pasid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [19:0] model [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  swq_top uut (.*);

  function automatic logic [7:0]  opc_of(input logic [19:0] id); return id[7:0] ^ 8'h5A; endfunction
  function automatic logic [63:0] src_of(input logic [19:0] id); return {24'hA0000, id, 20'h00001}; endfunction
  function automatic logic [63:0] dst_of(input logic [19:0] id); return {24'hB1111, ~id, 20'h00002}; endfunction
  function automatic logic [63:0] cml_of(input logic [19:0] id); return {id, 24'hC22222, id}; endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, read reply at next negedge
  task automatic submit(input logic [19:0] id, input logic rdy, input logic [1:0] exp, input string req);
    sub_valid = 1'b1; sub_pasid = id; sub_opcode = opc_of(id);
    sub_src = src_of(id); sub_dst = dst_of(id); sub_cmpl = cml_of(id);
    deq_ready = rdy;
    @(posedge clk); @(negedge clk);
    sub_valid = 1'b0; sub_pasid = '0; sub_opcode = '0; sub_src = '0; sub_dst = '0; sub_cmpl = '0;
    deq_ready = 1'b0;
    check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({req, " rsp_code"}, 64'(rsp_code), 64'(exp));
  endtask

  task automatic check_head(input string req);
    logic [19:0] id = model[0];
    check({req, " valid"}, 64'(deq_valid), 64'd1);
    check({req, " id"}, 64'(deq_pasid), 64'(id));
    check({req, " opcode"}, 64'(deq_opcode), 64'(opc_of(id)));
    check({req, " src"}, deq_src, src_of(id));
    check({req, " dst"}, deq_dst, dst_of(id));
    check({req, " cmpl"}, deq_cmpl, cml_of(id));
  endtask

  task automatic drain(input string req);
    while (model.size() > 0) begin
      check_head(req);
      deq_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      deq_ready = 1'b0;
      void'(model.pop_front());
    end
    check({req, " empty"}, 64'(deq_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 deq_valid", 64'(deq_valid), 64'd0);
    check("R8 rsp_valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 no strobe no reply", 64'(rsp_valid), 64'd0);

    // table walk: fill from empty, zero ID rejected, 17th valid ID retried
    for (int i = 0; i < NVEC; i++) begin
      submit(VEC[i][19:0], 1'b0, VEC[i][21:20], "R3/R4/R5 table");
      if (VEC[i][21:20] == 2'b00) model.push_back(VEC[i][19:0]);
      if (i == 0) check_head("R9 first entry visible");
    end

    // R5: zero ID on a full queue gives error, not retry
    submit(20'h00000, 1'b0, 2'b10, "R5 precedence");
    // R4: full queue with a same-edge dequeue still retries
    submit(20'h0DEAD, 1'b1, 2'b01, "R4 full+deq");
    void'(model.pop_front());
    // R7: a stalled head stays put
    check_head("R7 stall a");
    @(negedge clk);
    check_head("R7 stall b");
    // R3: space freed by the dequeue, now accepted
    submit(20'h0CAFE, 1'b0, 2'b00, "R3 refill");
    model.push_back(20'h0CAFE);
    submit(20'h0F00D, 1'b0, 2'b01, "R4 full again");
    // R6: order and fields preserved
    drain("R6 drain");

    // R10: accept and pop on one edge keeps occupancy at one
    submit(20'h00101, 1'b0, 2'b00, "R10 first");
    model.push_back(20'h00101);
    check_head("R9 into empty");
    submit(20'h00202, 1'b1, 2'b00, "R10 swap");
    void'(model.pop_front());
    model.push_back(20'h00202);
    check_head("R10 new head");
    drain("R10 drain");
    // R1: whole descriptor captured from a single-cycle strobe
    submit(20'hABCDE, 1'b0, 2'b00, "R1 capture");
    model.push_back(20'hABCDE);
    drain("R1 fields");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule